// File: doc/BRIEF.md
# Multicycle Sixteen-Bit Controller-Datapath Processor Core

This block is a small 16-bit processor built as a control state machine driving an explicit datapath. The datapath holds a program counter, an instruction register, a sixteen-entry register file, a single ALU and the multiplexers that pick the register-file write source, the memory address and the memory write data. The core fetches one instruction word at a time from a single word-addressed memory shared by code and data, decodes a 4-bit opcode, and spends one or two execute cycles on it before fetching the next word.

The instruction word carries the opcode in bits 15:12. The first register index `rn` sits in bits 11:8 and the second register index `rm` in bits 7:4. An 8-bit field in bits 7:0 serves as the direct address, the immediate or the jump target. Seven opcodes are defined: load from a direct address, store to a direct address, store through a register, load immediate, add, subtract and jump-if-zero. The remaining nine codes do nothing.

Memory reads are synchronous with one cycle of latency. The controller therefore spends a wait state after each read it issues. The states are:

- `S_RST`: reset.
- `S_FETCH`: issue the instruction read.
- `S_FWAIT`: capture the instruction and step the PC.
- `S_DECODE`.
- The execute states `S_LOAD` and `S_LWAIT` (direct load), `S_STORE`, `S_STIND`, `S_LDIMM`, `S_ADD`, `S_SUB`, `S_JZ` and `S_NOP`.

The transitions are:

- `S_RST` goes to `S_FETCH`.
- `S_FETCH` goes to `S_FWAIT`, and `S_FWAIT` goes to `S_DECODE`.
- `S_DECODE` branches on the opcode to its execute state.
- `S_LOAD` goes to `S_LWAIT`.
- Every other execute state, and `S_LWAIT`, returns to `S_FETCH`.

Top module: `fsmd_core`

## Requirements
- R1: While `rst_n` is low the core neither reads nor writes memory. After release, the first instruction read is at address 0.
- R2: An instruction read presents the PC on `mem_addr` with `mem_rd` high. The word returned one cycle later becomes the instruction, and the PC advances by one, wrapping modulo 2^16.
- R3: Opcode 0000 reads memory at the zero-extended 8-bit field and writes the returned word into register `rn`.
- R4: Opcode 0001 writes register `rn` to memory at the zero-extended 8-bit field. `mem_wr` is high only in the two store states.
- R5: Opcode 0010 writes register `rm` to memory at the address held in register `rn`.
- R6: Opcode 0011 writes the 8-bit field, zero-extended, into register `rn`.
- R7: Opcode 0100 sets `rn` to `rn + rm` and opcode 0101 sets `rn` to `rn - rm`, both modulo 2^16.
- R8: Opcode 0110 loads the PC with the zero-extended 8-bit field when register `rn` is zero. Otherwise the PC keeps the address of the next word.
- R9: Opcodes 0111 to 1111 change no register and no memory, and the core returns to fetch.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Word address to memory |
| mem_wdata | output | 16 | Write data to memory |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |

## Verification
The checks assume a memory that returns `mem_rdata` exactly one cycle after a cycle with `mem_rd` high. They also assume that `rst_n` is held low across at least one clock edge. The bench memory is a registered array that updates its read data only on read cycles, and every reset it applies lasts several cycles. Every address the test program touches stays below the model depth of 256 words, so the model's address truncation never aliases two locations.

// File: rtl/fsmd_pkg.sv
package fsmd_pkg;

    typedef enum logic [3:0] {
        S_RST, S_FETCH, S_FWAIT, S_DECODE,
        S_LOAD, S_LWAIT, S_STORE, S_STIND,
        S_LDIMM, S_ADD, S_SUB, S_JZ, S_NOP
    } core_state_e;

    localparam logic [3:0] OP_LOAD  = 4'h0;
    localparam logic [3:0] OP_STORE = 4'h1;
    localparam logic [3:0] OP_STIND = 4'h2;
    localparam logic [3:0] OP_LDIMM = 4'h3;
    localparam logic [3:0] OP_ADD   = 4'h4;
    localparam logic [3:0] OP_SUB   = 4'h5;
    localparam logic [3:0] OP_JZ    = 4'h6;

    typedef enum logic [1:0] {SRC_ALU = 2'b00, SRC_MEM = 2'b01, SRC_IMM = 2'b10} wsrc_e;
    typedef enum logic [1:0] {ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_PASS = 2'b10} aluop_e;
    typedef enum logic [1:0] {ADR_PC = 2'b00, ADR_FLD = 2'b01, ADR_REG = 2'b10} asel_e;

endpackage

// File: rtl/fsmd_alu.sv
module fsmd_alu
    import fsmd_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  aluop_e        op,
    output logic [DW-1:0] y,
    output logic          zero
);
    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            default: y = a;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/fsmd_regfile.sv
module fsmd_regfile #(
    parameter int DW   = 16,
    parameter int NREG = 16,
    localparam int RAW = $clog2(NREG)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [RAW-1:0] ra1,
    input  logic [RAW-1:0] ra2,
    output logic [DW-1:0]  rd1,
    output logic [DW-1:0]  rd2,
    input  logic           we,
    input  logic [RAW-1:0] wa,
    input  logic [DW-1:0]  wd
);
    logic [DW-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (we && wa == RAW'(g))
                regs[g] <= wd;
        end
    end

    assign rd1 = regs[ra1];
    assign rd2 = regs[ra2];
endmodule

// File: rtl/fsmd_ctrl.sv
module fsmd_ctrl
    import fsmd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  opcode,
    input  logic        alu_zero,
    output core_state_e state_o,
    output logic        ir_ld,
    output logic        pc_clr,
    output logic        pc_inc,
    output logic        pc_ld,
    output logic        rf_we,
    output wsrc_e       rf_src,
    output aluop_e      alu_op,
    output asel_e       addr_sel,
    output logic        wd_sel_rm,
    output logic        mem_rd,
    output logic        mem_wr
);
    core_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_RST;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = S_FETCH;
        unique case (state_q)
            S_RST:    state_d = S_FETCH;
            S_FETCH:  state_d = S_FWAIT;
            S_FWAIT:  state_d = S_DECODE;
            S_DECODE: begin
                unique case (opcode)
                    OP_LOAD:  state_d = S_LOAD;
                    OP_STORE: state_d = S_STORE;
                    OP_STIND: state_d = S_STIND;
                    OP_LDIMM: state_d = S_LDIMM;
                    OP_ADD:   state_d = S_ADD;
                    OP_SUB:   state_d = S_SUB;
                    OP_JZ:    state_d = S_JZ;
                    default:  state_d = S_NOP;
                endcase
            end
            S_LOAD:   state_d = S_LWAIT;
            default:  state_d = S_FETCH;
        endcase
    end

    always_comb begin
        ir_ld     = 1'b0;
        pc_clr    = 1'b0;
        pc_inc    = 1'b0;
        pc_ld     = 1'b0;
        rf_we     = 1'b0;
        rf_src    = SRC_ALU;
        alu_op    = ALU_PASS;
        addr_sel  = ADR_PC;
        wd_sel_rm = 1'b0;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        unique case (state_q)
            S_RST:   pc_clr = 1'b1;
            S_FETCH: begin
                addr_sel = ADR_PC;
                mem_rd   = 1'b1;
            end
            S_FWAIT: begin
                ir_ld  = 1'b1;
                pc_inc = 1'b1;
            end
            S_LOAD: begin
                addr_sel = ADR_FLD;
                mem_rd   = 1'b1;
            end
            S_LWAIT: begin
                rf_we  = 1'b1;
                rf_src = SRC_MEM;
            end
            S_STORE: begin
                addr_sel = ADR_FLD;
                mem_wr   = 1'b1;
            end
            S_STIND: begin
                addr_sel  = ADR_REG;
                wd_sel_rm = 1'b1;
                mem_wr    = 1'b1;
            end
            S_LDIMM: begin
                rf_we  = 1'b1;
                rf_src = SRC_IMM;
            end
            S_ADD: begin
                rf_we  = 1'b1;
                alu_op = ALU_ADD;
            end
            S_SUB: begin
                rf_we  = 1'b1;
                alu_op = ALU_SUB;
            end
            S_JZ: begin
                alu_op = ALU_PASS;
                pc_ld  = alu_zero;
            end
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/fsmd_core.sv
module fsmd_core
    import fsmd_pkg::*;
#(
    parameter int DW   = 16,
    parameter int NREG = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [DW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    output logic          mem_rd,
    output logic          mem_wr
);
    localparam int RAW = $clog2(NREG);
    localparam int FLD = 8;

    core_state_e   state;
    logic          ir_ld, pc_clr, pc_inc, pc_ld, rf_we, wd_sel_rm, alu_zero;
    wsrc_e         rf_src;
    aluop_e        alu_op;
    asel_e         addr_sel;
    logic [DW-1:0] pc_q, ir_q;
    logic [DW-1:0] rd1, rd2, alu_y, rf_wd, fld_ext;
    logic [RAW-1:0] rn, rm;

    assign rn      = ir_q[8 +: RAW];
    assign rm      = ir_q[4 +: RAW];
    assign fld_ext = {{(DW-FLD){1'b0}}, ir_q[FLD-1:0]};

    fsmd_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .opcode    (ir_q[DW-1 -: 4]),
        .alu_zero  (alu_zero),
        .state_o   (state),
        .ir_ld     (ir_ld),
        .pc_clr    (pc_clr),
        .pc_inc    (pc_inc),
        .pc_ld     (pc_ld),
        .rf_we     (rf_we),
        .rf_src    (rf_src),
        .alu_op    (alu_op),
        .addr_sel  (addr_sel),
        .wd_sel_rm (wd_sel_rm),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    fsmd_regfile #(.DW(DW), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rn),
        .ra2   (rm),
        .rd1   (rd1),
        .rd2   (rd2),
        .we    (rf_we),
        .wa    (rn),
        .wd    (rf_wd)
    );

    fsmd_alu #(.DW(DW)) u_alu (
        .a    (rd1),
        .b    (rd2),
        .op   (alu_op),
        .y    (alu_y),
        .zero (alu_zero)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pc_q <= '0;
        else if (pc_clr) pc_q <= '0;
        else if (pc_ld)  pc_q <= fld_ext;
        else if (pc_inc) pc_q <= pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     ir_q <= '0;
        else if (ir_ld) ir_q <= mem_rdata;
    end

    always_comb begin
        unique case (rf_src)
            SRC_MEM: rf_wd = mem_rdata;
            SRC_IMM: rf_wd = fld_ext;
            default: rf_wd = alu_y;
        endcase
    end

    always_comb begin
        unique case (addr_sel)
            ADR_FLD: mem_addr = fld_ext;
            ADR_REG: mem_addr = rd1;
            default: mem_addr = pc_q;
        endcase
    end

    assign mem_wdata = wd_sel_rm ? rd2 : rd1;
endmodule

// File: rtl/fsmd_core_chk.sv
module fsmd_core_chk
    import fsmd_pkg::*;
#(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_rd,
    input logic          mem_wr,
    input logic [DW-1:0] mem_addr,
    input core_state_e   state,
    input logic [DW-1:0] pc_q
);
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr)); // R10

    AST_FIRST_FETCH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH && $past(state) == S_RST) |-> (pc_q == '0)); // R1

    AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FETCH) |-> (mem_rd && mem_addr == pc_q)); // R2

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FWAIT) |=> (pc_q == DW'($past(pc_q) + 1'b1))); // R2

    AST_WR_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (state == S_STORE || state == S_STIND)); // R4

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NOP) |-> (!mem_wr && !mem_rd)); // R9

    AST_NOP_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_NOP) |=> (state == S_FETCH)); // R9
endmodule

bind fsmd_core fsmd_core_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .state    (state),
    .pc_q     (pc_q)
);

// File: tb/sim_fsmd_core.sv
module sim_fsmd_core;
    localparam int DW    = 16;
    localparam int DEPTH = 256;
    localparam int NPROG = 21;
    localparam int NEXP  = 6;

    // Program: count-down sum of 10..1 into R0, then stores and corner cases.
    localparam logic [15:0] PROG [NPROG] = '{
        16'h3000, 16'h310A, 16'h3201, 16'h3300, 16'h6108, 16'h4010, 16'h5120,
        16'h6304, 16'h1064, 16'h34C8, 16'h7020, 16'h2400, 16'h0564, 16'h1565,
        16'h5620, 16'h1666, 16'h37FF, 16'h1767, 16'h4620, 16'h1668, 16'h6314
    };

    // {address, expected word}
    localparam logic [31:0] EXP [NEXP] = '{
        {16'd100, 16'd55},   // R4, R7, R8: sum stored direct
        {16'd200, 16'd55},   // R5, R9: indirect store after no-op
        {16'd101, 16'd55},   // R3: loaded back then stored
        {16'd102, 16'hFFFF}, // R7: subtract wraps
        {16'd103, 16'h00FF}, // R6: immediate zero-extended
        {16'd104, 16'h0000}  // R7: add wraps
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;
    logic          mem_rd, mem_wr;
    logic [15:0]   mem [DEPTH];
    int            wr_count = 0;
    int            bad_wr = 0;
    int            errors = 0;
    int            checks = 0;

    always #4 clk = ~clk;

    fsmd_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= (i < NPROG) ? PROG[i] : 16'hDEAD;
            mem_rdata <= '0;
        end else begin
            if (mem_wr) begin
                mem[mem_addr[7:0]] <= mem_wdata;
                wr_count <= wr_count + 1;
                if (!(mem_addr inside {16'd100, 16'd101, 16'd102, 16'd103, 16'd104, 16'd200}))
                    bad_wr <= bad_wr + 1;
            end
            if (mem_rd) mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reset_and_check();
        int n = 0;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) begin
            @(negedge clk);
            n += (mem_rd || mem_wr) ? 1 : 0;
        end
        check("R1 no access in reset", n, 0);
        rst_n = 1'b1;
        n = 0;
        while (!mem_rd && n < 10) begin
            @(negedge clk);
            n++;
        end
        check("R1 first fetch address", {15'd0, mem_rd, mem_addr}, {15'd0, 1'b1, 16'd0});
    endtask

    initial begin
        int cyc;
        int wsave;
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int cyc;
        int wsave;
        reset_and_check();

        // R2, R8: run to the final store, watching for a hang
        cyc = 0;
        while (!(mem_wr && mem_addr == 16'd104) && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check("R2 R8 program reached final store", {31'd0, cyc < 5000}, 32'd1);
        repeat (3) @(negedge clk);

        for (int k = 0; k < NEXP; k++)
            check($sformatf("R3-R9 vector %0d mem[%0d]", k, EXP[k][31:16]),
                  {16'd0, mem[EXP[k][23:16]]}, {16'd0, EXP[k][15:0]});

        check("R4 R5 write count", wr_count, NEXP);
        check("R9 no stray writes", bad_wr, 0);

        // R8: the always-taken jump at the end holds the core with no writes
        wsave = wr_count;
        repeat (60) @(negedge clk);
        check("R8 halt loop writes", wr_count, wsave);

        // R10: read and write never together over a window
        cyc = 0;
        repeat (40) begin
            @(negedge clk);
            cyc += (mem_rd && mem_wr) ? 1 : 0;
        end
        check("R10 exclusive access", cyc, 0);

        // R1: reset in the middle of a run restarts at address 0
        reset_and_check();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule